// File: doc/BRIEF.md
# Over-Voltage Event and Interrupt Register Block

This block watches six connector-side pins for over-voltage and reports what it sees to a host through a small register file. Each pin has an analog comparator outside the block. Its output arrives asynchronously and is brought into the clock domain by a two-stage synchroniser. The block then keeps three views of the pins:

- a live status register that follows the present condition;
- a sticky flag register that remembers any trip until the host reads it;
- a mask register that decides which flags may raise the interrupt line.

The interrupt line is active low and open drain. While any pin is over voltage, the block forces off the routing-switch enable for that pin. A plain register port with write and read strobes stands in for the serial byte engine. The block also forms the 7-bit bus address from a strap input.

The pin order is the same in the mask, flag and status registers:

| Bit | Pin |
|-----|-----|
| 5 | DP_R |
| 4 | DN_L |
| 3 | SBU1 |
| 2 | SBU2 |
| 1 | GSBU1 |
| 0 | GSBU2 |

Top module: `ovp_irq_regs`

## Requirements
- R1: After reset the mask, flag and status registers read 0x00 and `irq_n` is 1 (line released).
- R2: Address 0x00 reads the constant 0x09. A write to it has no effect.
- R3: `slave_addr` equals binary 100001 followed by `addr_sel` in bit 0.
- R4: Address 0x03 returns the synchronised comparator levels in the pin order above, with bits 7:6 at 0. A change on `ovp_raw` appears there within three clock edges.
- R5: A flag bit in address 0x02 sets while its pin's status bit is 1. It stays set after the condition goes away, until the flag register is read.
- R6: A read strobe at address 0x02 returns the flags and clears them at that clock edge. A read strobe at any other address clears nothing.
- R7: A pin whose status bit is 1 in the cycle the flag register is read keeps its flag set after the clear.
- R8: Address 0x01 holds a 7-bit mask written through the register port. Bit 7 reads as 0.
- R9: With mask bit 6 at 0, `irq_n` is 0 exactly when some flag bit is 1 and its mask bit (same position) is 0.
- R10: With mask bit 6 at 1, `irq_n` is 1 whatever the flags and bits 5..0 hold.
- R11: `sw_en` equals `sw_req` with each bit forced to 0 while that pin's status bit is 1.
- R12: Writes to addresses 0x02 and 0x03 leave those registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovp_raw | input | 6 | Asynchronous comparator outputs, 1 = over voltage |
| sw_req | input | 6 | Requested routing-switch enables per pin |
| sw_en | output | 6 | Routing-switch enables after protection gating |
| addr_sel | input | 1 | Address strap |
| slave_addr | output | 7 | Bus address of the device |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears flags when reading 0x02 |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Interrupt, 0 = pull line low, 1 = released |

## Verification
The interrupt and flag logic is tried with single-pin trips, with all pins at once, and with random six-bit patterns held over random masks.

- Random masks with the global bit both set and clear separate a per-pin masking fault from a fault in the global override.
- Reading the flags while a condition is still present, and again once it has gone, separates a lost event from a missed clear.
- Reads of other addresses and writes to the read-only addresses show whether a side effect leaks into the flags or the status register.

// File: rtl/ovp_irq_regs.sv
module ovp_irq_regs #(
  parameter int           NPINS       = 6,
  parameter int           AW          = 8,
  parameter logic [7:0]   ID_VALUE    = 8'h09,
  parameter logic [5:0]   ADDR_PREFIX = 6'b100001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] ovp_raw,
  input  logic [NPINS-1:0] sw_req,
  output logic [NPINS-1:0] sw_en,
  input  logic             addr_sel,
  output logic [6:0]       slave_addr,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_rd,
  output logic [7:0]       reg_rdata,
  output logic             irq_n
);
  localparam logic [AW-1:0] A_ID   = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_FLAG = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam int            GBIT   = NPINS;

  logic [NPINS-1:0] meta_q, stat_q, flag_q, eff_mask;
  logic [NPINS:0]   mask_q;
  logic             rd_clr;

  assign rd_clr = reg_rd && (reg_addr == A_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stat_q <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      meta_q <= ovp_raw;
      stat_q <= meta_q;
      flag_q <= (rd_clr ? '0 : flag_q) | stat_q;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NPINS:0];
    end
  end

  assign eff_mask   = mask_q[GBIT] ? '1 : mask_q[NPINS-1:0];
  assign irq_n      = ~|(flag_q & ~eff_mask);
  assign sw_en      = sw_req & ~stat_q;
  assign slave_addr = {ADDR_PREFIX, addr_sel};

  always_comb begin
    case (reg_addr)
      A_ID:    reg_rdata = ID_VALUE;
      A_MASK:  reg_rdata = 8'(mask_q);
      A_FLAG:  reg_rdata = 8'(flag_q);
      A_STAT:  reg_rdata = 8'(stat_q);
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/ovp_irq_checker.sv
module ovp_irq_checker #(
  parameter int NPINS = 6,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] flags,
  input logic [NPINS:0]   mask,
  input logic [NPINS-1:0] sw_en,
  input logic             irq_n
);
  logic clr;
  assign clr = reg_rd && (reg_addr == AW'(2));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && status == '0) |=> (flags == '0));

  assert_no_lost_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |=> ((flags & $past(status)) == $past(status)));

  assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> irq_n);

  assert_global_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask[NPINS] |-> irq_n);

  assert_switch_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en & status) == '0));
endmodule

bind ovp_irq_regs ovp_irq_checker #(.NPINS(NPINS), .AW(AW)) u_ovp_irq_checker (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .status(stat_q), .flags(flag_q), .mask(mask_q), .sw_en(sw_en), .irq_n(irq_n)
);

// File: tb/test_ovp_irq_regs.sv
module test_ovp_irq_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] ovp_raw = '0, sw_req = '0, sw_en;
  logic       addr_sel = 0;
  logic [6:0] slave_addr;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic       reg_wr = 0, reg_rd = 0, irq_n;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ovp_irq_regs i_ovp_irq_regs (
    .clk(clk), .rst_n(rst_n), .ovp_raw(ovp_raw), .sw_req(sw_req), .sw_en(sw_en),
    .addr_sel(addr_sel), .slave_addr(slave_addr), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic logic irq_exp(logic [5:0] f, logic [6:0] m);
    return m[6] ? 1'b1 : ~|(f & ~m[5:0]);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    step(1);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    step(1);
    reg_rd = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [5:0] mflags;
    logic [6:0] mmask;
    void'($urandom(32'd20240611));
    step(2); rst_n = 1; step(1);

    check("R1 irq", irq_n, 1);
    rd(8'h01, d); check("R1 mask", d, 0);
    rd(8'h02, d); check("R1 flag", d, 0);
    rd(8'h03, d); check("R1 stat", d, 0);

    rd(8'h00, d); check("R2 id", d, 8'h09);
    wr(8'h00, 8'h55); rd(8'h00, d); check("R2 id after write", d, 8'h09);

    addr_sel = 0; #1 check("R3 addr0", slave_addr, 7'h42);
    addr_sel = 1; #1 check("R3 addr1", slave_addr, 7'h43);

    wr(8'h01, 8'hFF); rd(8'h01, d); check("R8 mask bit7", d, 8'h7F);
    wr(8'h01, 8'h00);

    // single pin trip on SBU1 (bit 3)
    sw_req = 6'h3F; ovp_raw = 6'b001000; step(3);
    rd(8'h03, d); check("R4 status sbu1", d, 8'h08);
    check("R11 gate", sw_en, 6'h37);
    check("R9 irq low", irq_n, 0);
    wr(8'h03, 8'h00); wr(8'h02, 8'h00);
    rd(8'h03, d); check("R12 stat write", d, 8'h08);
    ovp_raw = 0; step(3);
    rd(8'h03, d); check("R4 status cleared", d, 0);
    rd(8'h01, d);
    rd(8'h02, d); check("R5 sticky", d, 8'h08);
    rd(8'h02, d); check("R6 cleared", d, 0);
    check("R9 irq released", irq_n, 1);

    // read of other address must not clear
    ovp_raw = 6'b100001; step(3); ovp_raw = 0; step(3);
    rd(8'h03, d); rd(8'h00, d);
    rd(8'h02, d); check("R6 no side clear", d, 8'h21);

    // read while condition persists
    ovp_raw = 6'b000010; step(3);
    rd(8'h02, d); check("R7 read value", d, 8'h02);
    rd(8'h02, d); check("R7 kept", d, 8'h02);
    ovp_raw = 0; step(3); rd(8'h02, d); rd(8'h02, d);
    check("R6 empty", d, 0);

    // per-pin and global masks
    wr(8'h01, 8'h04); ovp_raw = 6'b000100; step(3);
    check("R9 masked pin", irq_n, 1);
    wr(8'h01, 8'h00); step(1);
    check("R9 unmasked pin", irq_n, 0);
    wr(8'h01, 8'h40); step(1);
    check("R10 global", irq_n, 1);
    ovp_raw = 6'h3F; step(3);
    check("R10 global all", irq_n, 1);
    rd(8'h03, d); check("R4 all", d, 8'h3F);
    check("R11 all off", sw_en, 0);
    ovp_raw = 0; step(3); rd(8'h02, d); rd(8'h02, d);

    mflags = 0; mmask = 7'h40;
    for (int i = 0; i < 300; i++) begin
      ovp_raw = 6'($urandom);
      sw_req  = 6'($urandom);
      if ($urandom % 3 == 0) begin
        mmask = 7'($urandom);
        wr(8'h01, {1'b0, mmask});
      end
      step(3);
      mflags |= ovp_raw;
      rd(8'h03, d); check("R4 random status", d, {2'b00, ovp_raw});
      check("R11 random gate", sw_en, sw_req & ~ovp_raw);
      check("R9 R10 random irq", irq_n, irq_exp(mflags, mmask));
      if ($urandom % 4 == 0) begin
        rd(8'h02, d); check("R5 random flags", d, {2'b00, mflags});
        mflags = ovp_raw;
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule